// File: doc/BRIEF.md
# Burst-Mode Flash Access Sequencer

This block is a command-driven front end for a small nonvolatile byte memory. A host fills or dumps a run of consecutive locations without ever sending a per-location address. It loads a start address, turns burst mode on, and then does one of two things. It writes each byte as two nibble writes, low half first. Or it issues read-memory commands, each of which returns one byte on a serial output. An internal address counter supplies the location and advances after every byte.

The host port carries two kinds of command. The first is a register write: a 4-bit selector plus one nibble of data. The second is a read-memory strobe. A finite state machine sequences the memory accesses and the serial shift-out. It has five states: `ST_IDLE`, `ST_WRITE`, `ST_FETCH`, `ST_LOAD` and `ST_SHIFT`. It makes these transitions:

- An accepted high-nibble write moves ST_IDLE to ST_WRITE.
- An accepted read moves ST_IDLE to ST_FETCH.
- ST_WRITE returns to ST_IDLE.
- ST_FETCH moves to ST_LOAD, and ST_LOAD moves to ST_SHIFT.
- ST_SHIFT returns to ST_IDLE after the last serial bit.

The memory itself is a simple synchronous array model.

Register selectors are: 0 data low nibble, 1 data high nibble, 2/3/4 start-address bits [3:0]/[7:4]/[10:8], 8 readback select, 13 burst control (bit 0 of the nibble is the enable).

Top module: `burst_flash_seq`

## Requirements
- R1: After reset, busy, err, burst_on and ser_valid are 0, and the readback select holds a nonzero value (4'hF), so reads stay disabled until the host programs it to 0.
- R2: With burst on, a write to selector 0 stores the low nibble and a write to selector 1 stores the high nibble. The selector-1 write makes busy high for exactly one cycle, starting the cycle after acceptance. In that cycle the byte {high,low} is written at the counter address, and the counter then advances by one.
- R3: When the counter's low SPAN_W bits are all ones, the next advance sets the whole counter to 0.
- R4: Selectors 2, 3 and 4 load start-address bits [3:0], [7:4] and [10:8] (bits at or above ADDR_W dropped), but only while burst is off. Such writes while burst is on change neither the address register nor the counter.
- R5: Selector 13 sets burst mode from bit 0 of the nibble; the value 0000 turns it off. The counter copies the address register only when burst goes from off to on. Re-writing 1 while already on leaves the counter alone.
- R6: With burst on and readback select 0, a read command fetches the byte at the counter. ser_valid rises on the third cycle after acceptance and stays high for 8 cycles. ser_out gives the byte MSB first, one bit per cycle. The counter advances by one.
- R7: A read command while burst is off, or while readback select is nonzero, is ignored: no serial output and no counter change. Serial output never starts without a read command.
- R8: While busy, every command is ignored. A nibble write (selector 0 or 1) or a read command arriving while busy sets err, which stays set until reset.
- R9: Turning burst off clears a pending low nibble to 0 and causes no memory write and no counter change.
- R10: Nibble writes to selectors 0 or 1 while burst is off are ignored and start no memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_wr | input | 1 | Register write strobe |
| cmd_sel | input | 4 | Register selector |
| cmd_nib | input | NIB_W | Register write data nibble |
| cmd_rd | input | 1 | Read-memory command strobe |
| busy | output | 1 | Memory access or shift-out in progress |
| err | output | 1 | Sticky error: nibble or read command seen while busy |
| burst_on | output | 1 | Burst mode enabled |
| ser_out | output | 1 | Serial read data, MSB first |
| ser_valid | output | 1 | ser_out carries a data bit |

## Verification
The bench builds the block with ADDR_W=6 and SPAN_W=4, which gives a 64-byte memory and a 16-location counter span. With that span, the wrap from a location whose low four bits are all ones back to address 0 is reached in three writes from 0x1E. Because the start is 0x1E rather than 0x0E, the wrap visibly clears an upper address bit as well. The smaller address also keeps the nibble-sliced address load short while still exercising truncation of the top slot.

// File: rtl/bfs_pkg.sv
package bfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_FETCH,
        ST_LOAD,
        ST_SHIFT
    } bfs_state_e;

    localparam int SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_DLO   = 4'd0;
    localparam logic [SEL_W-1:0] SEL_DHI   = 4'd1;
    localparam logic [SEL_W-1:0] SEL_A0    = 4'd2;
    localparam logic [SEL_W-1:0] SEL_A1    = 4'd3;
    localparam logic [SEL_W-1:0] SEL_A2    = 4'd4;
    localparam logic [SEL_W-1:0] SEL_RBK   = 4'd8;
    localparam logic [SEL_W-1:0] SEL_BURST = 4'd13;
endpackage

// File: rtl/bfs_flash_model.sv
module bfs_flash_model #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
        if (re) begin
            rdata <= cells[addr];
        end
    end
endmodule

// File: rtl/bfs_ser_shift.sv
module bfs_ser_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic         sdo,
    output logic         valid,
    output logic         last
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  sh_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            sh_q   <= din;
            left_q <= CW'(W);
        end else if (left_q != '0) begin
            sh_q   <= sh_q << 1;
            left_q <= left_q - 1'b1;
        end
    end

    assign sdo   = sh_q[W-1];
    assign valid = (left_q != '0);
    assign last  = (left_q == CW'(1));

    // R6: a load starts a shift-out on the next cycle
    a_r6_load_then_valid: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> valid);
    // R6: a new byte is only loaded once the previous one has fully left
    a_r6_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !valid);
endmodule

// File: rtl/burst_flash_seq.sv
module burst_flash_seq
    import bfs_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int SPAN_W = 10,
    parameter int NIB_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_wr,
    input  logic [3:0]       cmd_sel,
    input  logic [NIB_W-1:0] cmd_nib,
    input  logic             cmd_rd,
    output logic             busy,
    output logic             err,
    output logic             burst_on,
    output logic             ser_out,
    output logic             ser_valid
);
    localparam int DATA_W = 2 * NIB_W;

    bfs_state_e        state_q, state_d;
    logic              burst_q;
    logic [3:0]        rb_q;
    logic [ADDR_W-1:0] addr_q, cnt_q, cnt_next;
    logic [NIB_W-1:0]  lo_q, hi_q;
    logic              err_q;
    logic              wr_ok, rd_ok, hi_wr, rd_go, busy_hit;
    logic              mem_we, mem_re, sh_load, cnt_inc, sh_last;
    logic [DATA_W-1:0] mem_rdata;

    function automatic logic [ADDR_W-1:0] put_nib(
        input logic [ADDR_W-1:0] a,
        input int                slot,
        input logic [NIB_W-1:0]  v
    );
        logic [ADDR_W-1:0] r;
        r = a;
        for (int i = 0; i < NIB_W; i++) begin
            if (slot * NIB_W + i < ADDR_W) begin
                r[slot*NIB_W+i] = v[i];
            end
        end
        return r;
    endfunction

    assign busy     = (state_q != ST_IDLE);
    assign wr_ok    = cmd_wr && !busy;
    assign rd_ok    = cmd_rd && !busy;
    assign hi_wr    = wr_ok && burst_q && (cmd_sel == SEL_DHI);
    assign rd_go    = rd_ok && burst_q && (rb_q == 4'd0);
    assign busy_hit = busy && (cmd_rd ||
                      (cmd_wr && (cmd_sel == SEL_DLO || cmd_sel == SEL_DHI)));
    assign cnt_next = (cnt_q[SPAN_W-1:0] == {SPAN_W{1'b1}}) ? '0 : cnt_q + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (hi_wr) begin
                    state_d = ST_WRITE;
                end else if (rd_go) begin
                    state_d = ST_FETCH;
                end
            end
            ST_WRITE: state_d = ST_IDLE;
            ST_FETCH: state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: if (sh_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        mem_we  = 1'b0;
        mem_re  = 1'b0;
        sh_load = 1'b0;
        unique case (state_q)
            ST_WRITE: mem_we  = 1'b1;
            ST_FETCH: mem_re  = 1'b1;
            ST_LOAD:  sh_load = 1'b1;
            default:  ;
        endcase
        cnt_inc = mem_we || sh_load;
    end

    // command registers and address counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            burst_q <= 1'b0;
            rb_q    <= 4'hF;
            addr_q  <= '0;
            cnt_q   <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            err_q   <= 1'b0;
        end else begin
            if (busy_hit) begin
                err_q <= 1'b1;
            end
            if (wr_ok) begin
                case (cmd_sel)
                    SEL_DLO: if (burst_q) lo_q <= cmd_nib;
                    SEL_DHI: if (burst_q) hi_q <= cmd_nib;
                    SEL_A0:  if (!burst_q) addr_q <= put_nib(addr_q, 0, cmd_nib);
                    SEL_A1:  if (!burst_q) addr_q <= put_nib(addr_q, 1, cmd_nib);
                    SEL_A2:  if (!burst_q) addr_q <= put_nib(addr_q, 2, cmd_nib);
                    SEL_RBK: rb_q <= cmd_nib[3:0];
                    SEL_BURST: begin
                        burst_q <= cmd_nib[0];
                        if (cmd_nib[0] && !burst_q) begin
                            cnt_q <= addr_q;
                        end
                        if (!cmd_nib[0]) begin
                            lo_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
            if (cnt_inc) begin
                cnt_q <= cnt_next;
            end
        end
    end

    bfs_flash_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .re    (mem_re),
        .addr  (cnt_q),
        .wdata ({hi_q, lo_q}),
        .rdata (mem_rdata)
    );

    bfs_ser_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (sh_load),
        .din   (mem_rdata),
        .sdo   (ser_out),
        .valid (ser_valid),
        .last  (sh_last)
    );

    assign err      = err_q;
    assign burst_on = burst_q;

    // R2: memory writes happen only inside a burst
    a_r2_write_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> burst_q);
    // R3: the counter wraps to zero at the end of its span
    a_r3_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_inc && cnt_q[SPAN_W-1:0] == {SPAN_W{1'b1}}) |=> (cnt_q == '0));
    // R4: inside a burst the counter moves only by advancing
    a_r4_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_q && !cnt_inc) |=> $stable(cnt_q));
    // R7: fetches only start with burst on and readback select 0
    a_r7_fetch_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |-> (burst_q && rb_q == 4'd0));
    // R8: the error flag is sticky
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: tb/burst_flash_seq_tb.sv
module burst_flash_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [3:0] cmd_sel = '0;
    logic [3:0] cmd_nib = '0;
    logic       cmd_rd = 1'b0;
    logic       busy, err, burst_on, ser_out, ser_valid;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] VEC [6] = '{8'h3C, 8'hA5, 8'h00, 8'hFF, 8'h81, 8'h7E};

    always #10 clk = ~clk;

    burst_flash_seq #(.ADDR_W(6), .SPAN_W(4), .NIB_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_sel(cmd_sel),
        .cmd_nib(cmd_nib), .cmd_rd(cmd_rd), .busy(busy), .err(err),
        .burst_on(burst_on), .ser_out(ser_out), .ser_valid(ser_valid)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // returns busy as seen one cycle after acceptance
    task automatic reg_wr(input logic [3:0] sel, input logic [3:0] nib, output logic seen_busy);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_sel = sel; cmd_nib = nib;
        @(negedge clk);
        cmd_wr = 1'b0;
        seen_busy = busy;
        for (int k = 0; k < 50 && busy; k++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] sel, input logic [3:0] nib);
        logic b;
        reg_wr(sel, nib, b);
    endtask

    task automatic set_addr(input logic [7:0] a);
        wr(4'd2, a[3:0]);
        wr(4'd3, a[7:4]);
        wr(4'd4, 4'd0);
    endtask

    task automatic wr_byte(input logic [7:0] b);
        wr(4'd0, b[3:0]);
        wr(4'd1, b[7:4]);
    endtask

    // lat = negedges until ser_valid seen, or 20 if never
    task automatic rd_byte(output logic [7:0] b, output int lat);
        @(negedge clk);
        cmd_rd = 1'b1;
        @(negedge clk);
        cmd_rd = 1'b0;
        lat = 1;
        b = '0;
        while (!ser_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        if (ser_valid) begin
            for (int i = 0; i < 8; i++) begin
                b = {b[6:0], ser_out};
                @(negedge clk);
            end
        end
        for (int k = 0; k < 50 && busy; k++) @(negedge clk);
    endtask

    task automatic repoint(input logic [7:0] a);
        wr(4'd13, 4'd0);
        set_addr(a);
        wr(4'd13, 4'd1);
    endtask

    initial begin
        logic [7:0] b;
        int lat;
        logic sb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 burst_on", burst_on, 0);
        chk("R1 ser_valid", ser_valid, 0);

        // R10 nibble writes with burst off start nothing
        reg_wr(4'd0, 4'h5, sb);
        chk("R10 lo busy", sb, 0);
        reg_wr(4'd1, 4'h6, sb);
        chk("R10 hi busy", sb, 0);

        // R1 readback select resets nonzero: read ignored
        set_addr(8'h05);
        wr(4'd13, 4'd1);
        chk("R5 burst_on", burst_on, 1);
        rd_byte(b, lat);
        chk("R1 rb reset blocks read", lat, 20);
        wr(4'd8, 4'd0);

        // vector table: burst write then read back
        for (int i = 0; i < 6; i++) begin
            wr(4'd0, VEC[i][3:0]);
            reg_wr(4'd1, VEC[i][7:4], sb);
            chk("R2 write busy", sb, 1);
        end
        repoint(8'h05);
        for (int i = 0; i < 6; i++) begin
            rd_byte(b, lat);
            chk("R2 R6 readback", b, VEC[i]);
            chk("R6 latency", lat, 3);
        end

        // R7 nonzero readback select and burst off block reads
        repoint(8'h08);
        wr(4'd8, 4'd3);
        rd_byte(b, lat);
        chk("R7 rb nonzero ignored", lat, 20);
        wr(4'd8, 4'd0);
        rd_byte(b, lat);
        chk("R7 counter kept", b, VEC[3]);
        wr(4'd13, 4'd0);
        rd_byte(b, lat);
        chk("R7 burst off ignored", lat, 20);
        repeat (10) @(negedge clk);
        chk("R7 no spontaneous stream", ser_valid, 0);

        // R4 address load during burst ignored
        repoint(8'h20);
        set_addr(8'h30);
        wr_byte(8'hA1);
        wr_byte(8'hB2);
        wr(4'd13, 4'd0);
        wr(4'd13, 4'd1);
        rd_byte(b, lat);
        chk("R4 addr load ignored 0", b, 8'hA1);
        rd_byte(b, lat);
        chk("R4 addr load ignored 1", b, 8'hB2);

        // R3 wrap from 0x1F to 0x00
        repoint(8'h1E);
        wr_byte(8'hC1);
        wr_byte(8'hC2);
        wr_byte(8'hC3);
        repoint(8'h00);
        rd_byte(b, lat);
        chk("R3 wrap to zero", b, 8'hC3);
        repoint(8'h1F);
        rd_byte(b, lat);
        chk("R3 last before wrap", b, 8'hC2);

        // R9 partial byte discarded on burst off
        repoint(8'h11);
        wr_byte(8'hEE);
        repoint(8'h11);
        reg_wr(4'd0, 4'h7, sb);
        chk("R9 lo no busy", sb, 0);
        wr(4'd13, 4'd0);
        wr(4'd13, 4'd1);
        rd_byte(b, lat);
        chk("R9 no write on discard", b, 8'hEE);
        repoint(8'h11);
        wr(4'd1, 4'h4);
        repoint(8'h11);
        rd_byte(b, lat);
        chk("R9 low nibble cleared", b, 8'h40);

        // R8 nibble write while busy ignored and flagged
        chk("R8 err clear before", err, 0);
        repoint(8'h28);
        wr(4'd0, 4'hA);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_sel = 4'd1; cmd_nib = 4'h5;
        @(negedge clk);
        cmd_sel = 4'd0; cmd_nib = 4'h3;
        @(negedge clk);
        cmd_wr = 1'b0;
        chk("R8 err set", err, 1);
        wr(4'd1, 4'h6);
        repoint(8'h28);
        rd_byte(b, lat);
        chk("R8 first byte", b, 8'h5A);
        // R5 re-enable while on does not reload counter
        wr(4'd13, 4'd1);
        rd_byte(b, lat);
        chk("R5 R8 second byte", b, 8'h6A);
        chk("R8 err sticky", err, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule